// File: doc/BRIEF.md
# Multiplexed 16-bit External Memory Bus Controller

This block sits between an 8-bit processor core and external memory reached over a multiplexed bus. The low 16 address bits and the 16 data bits share one set of lines, and up to four more address bits have lines of their own. The core hands the block one request at a time, either an instruction fetch or a single-byte table write. Each request carries a 21-bit byte pointer and an 8-bit data byte. Bit 0 of the pointer picks the byte within a word. Bits 20:1 form the word address that goes out on the address lines.

Every bus access runs through four fixed phases:
1. The address goes out with the latch strobe high.
2. The strobe drops while the address is held.
3. The read enable or the write strobe is active.
4. The bus is released and the block reports completion.

A 2-bit write-mode field selects how byte writes reach 16-bit memory:
- Byte Write pulses only the high or only the low write strobe.
- Word Write pairs an even byte with the following odd byte and writes them as one word.
- Byte Select marks the byte with upper/lower byte enables and a byte-address line.

Fetches always return a full 16-bit word in one access.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the bus is enabled and no access is in progress, so the core must hold its request until it is taken. Completion is a one-cycle `done` pulse with no back-pressure. For a fetch, `rd_word` is valid in the `done` cycle and holds until the next fetch completes.

The bus is enabled only when external memory mode is on, the core is not executing internally, and the device is not asleep. Otherwise it sits in a quiet state. Ownership outputs tell the pad logic which pins the bus claims, and claimed pins override every other function sharing them.

Top module: `xbus_ctrl`

## Requirements
- R1: While the bus is disabled (`ext_mode`=0, `int_exec`=1 or `sleep`=1): `ad_oe` and `ahi_oe` are 0; `ce_n`, `oe_n`, `wrh_n`, `wrl_n`, `ub_n` and `lb_n` are 1; `ale` and `ba0` are 0; `req_ready` is 0.
- R2: `ad_own` equals `ext_mode`. `ahi_own` equals `ext_mode` AND `wide` (`wide`=1 selects the 20-bit address width, `wide`=0 the 16-bit width). `ahi_oe` is 1 only when `wide`=1.
- R3: While `sleep`=1, `ce_n` is 1 and no request is accepted.
- R4: A bus access runs in this order, counting from the cycle after acceptance:
  - Cycle 1: `ale`=1, with `ad_oe`=1 and `ad_out`=ptr[16:1].
  - Cycle 2: `ale`=0, with the same address still driven.
  - Cycle 3: the data/strobe phase.
  - Cycle 4: `done`=1.
- R5: For a fetch, cycle 3 has `oe_n`=0 and `ad_oe`=0, and `rd_word` in cycle 4 equals the value of `ad_in` during cycle 3.
- R6: `ce_n` is 0 in all four cycles of every bus access, whether read or write, and 1 at all other times.
- R7: Mode 00 (Byte Write): a write drives {data,data} on `ad_out` in cycles 3 and 4. In cycle 3 it pulses only `wrh_n` low when ptr[0]=1, or only `wrl_n` low when ptr[0]=0. `ub_n`, `lb_n` stay 1 and `ba0` stays 0.
- R8: Mode 01 (Word Write): a write with ptr[0]=0 starts no bus access. It stores the byte, keeps `ce_n`=1 and gives `done`=1 in the cycle after acceptance.
- R9: Mode 01, write with ptr[0]=1: runs a bus access that drives {data, stored even byte} on `ad_out` in cycles 3 and 4. `wrh_n` and `wrl_n` are both low in cycle 3 only. `ub_n`, `lb_n` stay 1.
- R10: Mode 1x (Byte Select): a write pulses only `wrl_n`, drives {data,data}, and holds `ba0`=ptr[0] for all four cycles. It also holds `ub_n`=0 if ptr[0]=1, or `lb_n`=0 if ptr[0]=0. A fetch holds both `ub_n` and `lb_n` low with `ba0`=0. In modes 00 and 01, `ba0` is always 0.
- R11: With `wide`=1, `ahi_out`=ptr[20:17] and `ahi_oe`=1 in all four cycles of a bus access. With `wide`=0, `ahi_oe` stays 0.
- R12: `req_ready` is 0 from the cycle after acceptance until the cycle after `done`, when it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | External memory mode configured |
| int_exec | input | 1 | Core executing from internal memory |
| sleep | input | 1 | Device in sleep |
| wide | input | 1 | 1 = 20-bit address width, 0 = 16-bit |
| wmode | input | 2 | Write mode: 00 byte write, 01 word write, 1x byte select |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = table byte write, 0 = instruction fetch |
| req_ptr | input | 21 | Byte pointer |
| req_data | input | 8 | Write byte |
| ad_in | input | 16 | Sampled multiplexed bus lines |
| done | output | 1 | Access complete pulse |
| rd_word | output | 16 | Fetched word |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| ba0 | output | 1 | Byte address line |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for the multiplexed lines |
| ahi_out | output | 4 | Upper address bits |
| ahi_oe | output | 1 | Drive enable for the upper address lines |
| ad_own | output | 1 | Bus claims the multiplexed pins |
| ahi_own | output | 1 | Bus claims the upper address pins |

## Verification
The hardest behaviour to reach is the paired word write. Its bus data depends on a byte stored by an earlier even-address request that produced no bus activity at all. The sweep always issues the even byte and then the odd byte of the same word. The bench keeps its own copy of the stored byte, so both the silent even request and the combined odd write are checked. The quiet state caused by internal execution or sleep is entered only between requests, after a full sweep has left the sequencer's latches holding non-zero values. This shows that the forcing does not depend on that stale state.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HOLD = 3'd2,
    PH_DATA = 3'd3,
    PH_REL  = 3'd4
  } phase_t;

  localparam logic [1:0] WM_BYTE = 2'b00;
  localparam logic [1:0] WM_WORD = 2'b01;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [1:0]        wmode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [BYTE_W-1:0] req_data,
  output phase_t            phase,
  output logic              cyc_bus,
  output logic              lat_write,
  output logic [PTR_W-1:0]  lat_ptr,
  output logic [BYTE_W-1:0] lat_data,
  output logic [BYTE_W-1:0] even_byte,
  output logic              done
);
  logic accept;
  logic pair_lo;

  assign req_ready = active && (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign pair_lo   = req_write && (wmode == WM_WORD) && !req_ptr[0];
  assign done      = (phase == PH_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cyc_bus   <= 1'b0;
      lat_write <= 1'b0;
      lat_ptr   <= '0;
      lat_data  <= '0;
      even_byte <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          lat_write <= req_write;
          lat_ptr   <= req_ptr;
          lat_data  <= req_data;
          if (pair_lo) begin
            even_byte <= req_data;
            cyc_bus   <= 1'b0;
            phase     <= PH_REL;
          end else begin
            cyc_bus <= 1'b1;
            phase   <= PH_ADDR;
          end
        end
        PH_ADDR: phase <= PH_HOLD;
        PH_HOLD: phase <= PH_DATA;
        PH_DATA: phase <= PH_REL;
        PH_REL: begin
          phase   <= PH_IDLE;
          cyc_bus <= 1'b0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R8
  even_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pair_lo) |=> (done && !cyc_bus));
endmodule

// File: rtl/xbus_wdec.sv
module xbus_wdec
  import xbus_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int BYTE_W = 8
) (
  input  phase_t                    phase,
  input  logic                      cyc_bus,
  input  logic                      lat_write,
  input  logic [PTR_W-1:0]          lat_ptr,
  input  logic [BYTE_W-1:0]         lat_data,
  input  logic [BYTE_W-1:0]         even_byte,
  input  logic [1:0]                wmode,
  output logic                      bus,
  output logic                      ale,
  output logic                      oe_n,
  output logic                      wrh_n,
  output logic                      wrl_n,
  output logic                      ub_n,
  output logic                      lb_n,
  output logic                      ba0,
  output logic [2*BYTE_W-1:0]       ad_out,
  output logic                      ad_drive,
  output logic [PTR_W-2*BYTE_W-2:0] ahi_out
);
  localparam int AD_W = 2 * BYTE_W;

  logic              sel_mode;
  logic              word_mode;
  logic              odd;
  logic [AD_W-1:0]   wdata;

  assign sel_mode  = wmode[1];
  assign word_mode = (wmode == WM_WORD);
  assign odd       = lat_ptr[0];
  assign bus       = cyc_bus && (phase != PH_IDLE);
  assign wdata     = word_mode ? {lat_data, even_byte} : {lat_data, lat_data};
  assign ahi_out   = lat_ptr[PTR_W-1:AD_W+1];

  always_comb begin
    ale      = 1'b0;
    oe_n     = 1'b1;
    wrh_n    = 1'b1;
    wrl_n    = 1'b1;
    ad_drive = 1'b0;
    ad_out   = lat_ptr[AD_W:1];
    ub_n     = !(bus && sel_mode && (!lat_write || odd));
    lb_n     = !(bus && sel_mode && (!lat_write || !odd));
    ba0      = bus && sel_mode && lat_write && odd;
    if (bus) begin
      unique case (phase)
        PH_ADDR: begin
          ale      = 1'b1;
          ad_drive = 1'b1;
        end
        PH_HOLD: ad_drive = 1'b1;
        PH_DATA: begin
          if (lat_write) begin
            ad_drive = 1'b1;
            ad_out   = wdata;
            if (sel_mode) begin
              wrl_n = 1'b0;
            end else if (word_mode) begin
              wrh_n = 1'b0;
              wrl_n = 1'b0;
            end else begin
              wrh_n = !odd;
              wrl_n = odd;
            end
          end else begin
            oe_n = 1'b0;
          end
        end
        PH_REL: begin
          ad_drive = lat_write;
          if (lat_write) ad_out = wdata;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins #(
  parameter int AD_W = 16,
  parameter int HI_W = 4
) (
  input  logic            ext_mode,
  input  logic            int_exec,
  input  logic            sleep,
  input  logic            wide,
  input  logic            bus,
  input  logic            r_ale,
  input  logic            r_oe_n,
  input  logic            r_wrh_n,
  input  logic            r_wrl_n,
  input  logic            r_ub_n,
  input  logic            r_lb_n,
  input  logic            r_ba0,
  input  logic [AD_W-1:0] r_ad_out,
  input  logic            r_ad_drive,
  input  logic [HI_W-1:0] r_ahi_out,
  output logic            active,
  output logic            ale,
  output logic            ce_n,
  output logic            oe_n,
  output logic            wrh_n,
  output logic            wrl_n,
  output logic            ub_n,
  output logic            lb_n,
  output logic            ba0,
  output logic [AD_W-1:0] ad_out,
  output logic            ad_oe,
  output logic [HI_W-1:0] ahi_out,
  output logic            ahi_oe,
  output logic            ad_own,
  output logic            ahi_own
);
  logic live;

  assign active  = ext_mode && !int_exec && !sleep;
  assign live    = active && bus;
  assign ad_own  = ext_mode;
  assign ahi_own = ext_mode && wide;

  assign ale     = live && r_ale;
  assign ce_n    = !live;
  assign oe_n    = !live || r_oe_n;
  assign wrh_n   = !live || r_wrh_n;
  assign wrl_n   = !live || r_wrl_n;
  assign ub_n    = !live || r_ub_n;
  assign lb_n    = !live || r_lb_n;
  assign ba0     = live && r_ba0;
  assign ad_oe   = live && r_ad_drive;
  assign ad_out  = active ? r_ad_out : '0;
  assign ahi_oe  = live && wide;
  assign ahi_out = (active && wide) ? r_ahi_out : '0;
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int PTR_W  = 21,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              int_exec,
  input  logic              sleep,
  input  logic              wide,
  input  logic [1:0]        wmode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PTR_W-1:0]  req_ptr,
  input  logic [BYTE_W-1:0] req_data,
  input  logic [2*BYTE_W-1:0] ad_in,
  output logic              done,
  output logic [2*BYTE_W-1:0] rd_word,
  output logic              ale,
  output logic              ce_n,
  output logic              oe_n,
  output logic              wrh_n,
  output logic              wrl_n,
  output logic              ub_n,
  output logic              lb_n,
  output logic              ba0,
  output logic [2*BYTE_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [PTR_W-2*BYTE_W-2:0] ahi_out,
  output logic              ahi_oe,
  output logic              ad_own,
  output logic              ahi_own
);
  localparam int AD_W = 2 * BYTE_W;
  localparam int HI_W = PTR_W - AD_W - 1;

  phase_t            phase;
  logic              active, cyc_bus, lat_write, bus;
  logic [PTR_W-1:0]  lat_ptr;
  logic [BYTE_W-1:0] lat_data, even_byte;
  logic              r_ale, r_oe_n, r_wrh_n, r_wrl_n, r_ub_n, r_lb_n, r_ba0, r_drive;
  logic [AD_W-1:0]   r_ad_out;
  logic [HI_W-1:0]   r_ahi_out;

  xbus_seq #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .wmode(wmode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_ptr(req_ptr), .req_data(req_data), .phase(phase), .cyc_bus(cyc_bus),
    .lat_write(lat_write), .lat_ptr(lat_ptr), .lat_data(lat_data),
    .even_byte(even_byte), .done(done)
  );

  xbus_wdec #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_wdec (
    .phase(phase), .cyc_bus(cyc_bus), .lat_write(lat_write), .lat_ptr(lat_ptr),
    .lat_data(lat_data), .even_byte(even_byte), .wmode(wmode), .bus(bus),
    .ale(r_ale), .oe_n(r_oe_n), .wrh_n(r_wrh_n), .wrl_n(r_wrl_n),
    .ub_n(r_ub_n), .lb_n(r_lb_n), .ba0(r_ba0), .ad_out(r_ad_out),
    .ad_drive(r_drive), .ahi_out(r_ahi_out)
  );

  xbus_pins #(.AD_W(AD_W), .HI_W(HI_W)) u_pins (
    .ext_mode(ext_mode), .int_exec(int_exec), .sleep(sleep), .wide(wide),
    .bus(bus), .r_ale(r_ale), .r_oe_n(r_oe_n), .r_wrh_n(r_wrh_n),
    .r_wrl_n(r_wrl_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n), .r_ba0(r_ba0),
    .r_ad_out(r_ad_out), .r_ad_drive(r_drive), .r_ahi_out(r_ahi_out),
    .active(active), .ale(ale), .ce_n(ce_n), .oe_n(oe_n), .wrh_n(wrh_n),
    .wrl_n(wrl_n), .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0), .ad_out(ad_out),
    .ad_oe(ad_oe), .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ad_own(ad_own),
    .ahi_own(ahi_own)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else if (phase == PH_DATA && cyc_bus && !lat_write) rd_word <= ad_in;
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (ce_n && !ale && !ad_oe && !ahi_oe && wrh_n && wrl_n && oe_n && !ba0));

  // R3
  sleep_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (ce_n && !req_ready));

  // R4
  ale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && active) |=> (!ale && (!active || ($stable(ad_out) && ad_oe))));

  // R4
  ale_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> ##2 done);

  // R9
  pair_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrh_n && !wrl_n) |-> (wmode == WM_WORD));

  // R10
  ba0_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba0 |-> wmode[1]);

  // R5
  read_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (wrh_n && wrl_n && !ad_oe));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b0, int_exec = 1'b0, sleep = 1'b0, wide = 1'b0;
  logic [1:0]  wmode = 2'b00;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_ptr = '0;
  logic [7:0]  req_data = '0;
  logic [15:0] ad_in = '0;
  logic        req_ready, done, ale, ce_n, oe_n, wrh_n, wrl_n, ub_n, lb_n, ba0;
  logic        ad_oe, ahi_oe, ad_own, ahi_own;
  logic [15:0] rd_word, ad_out;
  logic [3:0]  ahi_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] bufm = 8'h00;

  always #2 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .int_exec(int_exec),
    .sleep(sleep), .wide(wide), .wmode(wmode), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_ptr(req_ptr),
    .req_data(req_data), .ad_in(ad_in), .done(done), .rd_word(rd_word),
    .ale(ale), .ce_n(ce_n), .oe_n(oe_n), .wrh_n(wrh_n), .wrl_n(wrl_n),
    .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0), .ad_out(ad_out), .ad_oe(ad_oe),
    .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ad_own(ad_own), .ahi_own(ahi_own)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl_now();
    return {ale, ce_n, oe_n, wrh_n, wrl_n, ub_n, lb_n, ba0};
  endfunction

  // expected {ale,ce_n,oe_n,wrh_n,wrl_n,ub_n,lb_n,ba0} in bus phase ph (1..4)
  function automatic logic [7:0] exp_ctl(input int ph, input bit w, input bit p0, input logic [1:0] m);
    logic e_ale, e_oe, e_wh, e_wl, e_ub, e_lb, e_ba;
    e_ale = (ph == 1);
    e_oe  = !(ph == 3 && !w);
    e_wh  = 1'b1;
    e_wl  = 1'b1;
    if (ph == 3 && w) begin
      if (m[1]) e_wl = 1'b0;
      else if (m == 2'b01) begin e_wh = 1'b0; e_wl = 1'b0; end
      else begin e_wh = !p0; e_wl = p0; end
    end
    e_ub = m[1] ? !(!w || p0) : 1'b1;
    e_lb = m[1] ? !(!w || !p0) : 1'b1;
    e_ba = m[1] && w && p0;
    return {e_ale, 1'b0, e_oe, e_wh, e_wl, e_ub, e_lb, e_ba};
  endfunction

  task automatic run_req(input bit w, input logic [20:0] p, input logic [7:0] d);
    bit bus;
    logic [15:0] wd;
    logic [15:0] rin;
    bus = !(w && wmode == 2'b01 && !p[0]);
    wd  = (w && wmode == 2'b01) ? {d, bufm} : {d, d};
    rin = {p[8:1], ~p[8:1]} ^ 16'h5a3c ^ {8'h00, d};
    ad_in     = rin;
    req_valid = 1'b1;
    req_write = w;
    req_ptr   = p;
    req_data  = d;
    check("R12 ready before accept", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    if (!bus) begin
      check("R8 quiet pins on even word byte", ctl_now(), 8'b0111_1110);
      check("R8 done after even byte", done, 1'b1);
      bufm = d;
      @(negedge clk);
    end else begin
      for (int ph = 1; ph <= 4; ph++) begin
        // R6 R7 R9 R10 control pins per phase
        check($sformatf("R6/R7/R9/R10 ctl ph%0d m%0d w%0d", ph, wmode, w),
              ctl_now(), exp_ctl(ph, w, p[0], wmode));
        check("R12 ready low while busy", req_ready, 1'b0);
        check("R4 done timing", done, (ph == 4));
        check("R11 upper enable", ahi_oe, wide);
        if (wide) check("R11 upper address", ahi_out, p[20:17]);
        if (ph <= 2) begin
          check("R4 address drive", ad_oe, 1'b1);
          check("R4 address value", ad_out, p[16:1]);
        end else if (w) begin
          check("R7 R9 R10 data drive", ad_oe, 1'b1);
          check("R7 R9 R10 data value", ad_out, wd);
        end else begin
          check("R5 released on read", ad_oe, 1'b0);
        end
        if (ph == 4 && !w) check("R5 fetched word", rd_word, rin);
        @(negedge clk);
      end
    end
    check("R12 ready after done", req_ready, 1'b1);
    check("R6 ce high after access", ce_n, 1'b1);
    check("R4 done cleared", done, 1'b0);
  endtask

  task automatic check_quiet(input string tag);
    check({tag, " ctl"}, ctl_now(), 8'b0111_1110);
    check({tag, " ad_oe"}, ad_oe, 1'b0);
    check({tag, " ahi_oe"}, ahi_oe, 1'b0);
    check({tag, " ready"}, req_ready, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 ext_mode off");
    // R2 ownership sweep
    for (int e = 0; e < 2; e++) begin
      for (int wv = 0; wv < 2; wv++) begin
        ext_mode = e[0];
        wide     = wv[0];
        @(negedge clk);
        check("R2 ad_own", ad_own, e[0]);
        check("R2 ahi_own", ahi_own, e[0] & wv[0]);
      end
    end
    ext_mode = 1'b1;
    // sweep modes, widths, kinds, byte lanes
    for (int m = 0; m < 4; m++) begin
      for (int wv = 0; wv < 2; wv++) begin
        for (int base = 0; base < 3; base++) begin
          for (int k = 0; k < 2; k++) begin
            for (int b = 0; b < 2; b++) begin
              logic [20:0] p;
              wmode = m[1:0];
              wide  = wv[0];
              p = ((21'h1A5F3 * (base + 1) + 21'h0B2C4 * m) & 21'h1FFFFE) | b[0];
              run_req(k[0], p, 8'h3C + 8'(m * 16 + base * 4 + k * 2 + b));
            end
          end
        end
      end
    end
    // quiet state after latches hold data
    int_exec = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    check_quiet("R1 internal execution");
    check("R1 no accept while internal", done, 1'b0);
    req_valid = 1'b0;
    int_exec = 1'b0;
    sleep = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    check("R3 ce high in sleep", ce_n, 1'b1);
    check("R3 not ready in sleep", req_ready, 1'b0);
    @(negedge clk);
    check("R3 no access begun in sleep", {ale, done}, 2'b00);
    req_valid = 1'b0;
    sleep = 1'b0;
    @(negedge clk);
    wmode = 2'b00;
    wide = 1'b0;
    run_req(1'b1, 21'h000013, 8'hA7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule